// File: doc/BRIEF.md
# Multicycle Issue Interlock

This block is the decode-stage issue controller of an in-order, five-stage pipeline whose execute stage holds several units of different length. Every cycle it looks at the instruction waiting in decode: its unit class, its destination register, its source registers and their enable flags. It then either lets the instruction issue or holds it in decode. A held instruction keeps the fetch and decode registers frozen, and the execute side sees a bubble, which is simply the absence of `issue_o`.

Four hazards are tracked.
- **Read-after-write (RAW).** Each register has a ready countdown, so a consumer waits until its producer's latency has run out. Full forwarding is assumed.
- **Write-after-write (WAW).** Each register also has a countdown to the memory-stage entry of its newest writer. A later writer is held until it is certain to reach that stage strictly after the earlier one.
- **Busy divider.** The divider is not pipelined, so a second divide waits out its repeat interval.
- **Write-back port.** There is one memory/write-back path. A shift register of future-cycle reservations stops two instructions from entering that path in the same cycle.

Write-after-read (WAR) needs no check, because operands are read in order in decode.

Top module: `iil_issue_ctl`

## Requirements
- R1: After a synchronous reset, no operation is in flight. A valid instruction of any class, including a divide, issues in the first cycle it is presented.
- R2: While `in_valid` is 0, `issue_o`, `stall_o` and `cause_o` are all 0. The other inputs are ignored and change no state.
- R3: A source with its enable set, whose register was last written by an instruction issued in cycle t, cannot issue before cycle t+L+1. L is the latency of the producer's class: integer 0, load/store 1, FP add 3, multiply 6, divide 24. A source whose enable is 0 is never checked.
- R4: An instruction enters the memory stage D+1 cycles after it issues. D is its execute depth: integer 1, load/store 1, FP add 4, multiply 7, divide 25. A writer whose destination has an earlier writer still in flight is held until its own memory-stage cycle is strictly later than that writer's.
- R5: A divide issued in cycle t blocks any other divide until cycle t+25. The divide presented in cycle t+24 stalls, and the one presented in cycle t+25 issues.
- R6: No instruction issues if its memory-stage cycle, as defined in R4, is already taken by an instruction in flight. This applies to every class, stores included.
- R7: `issue_o` is `in_valid` with no hazard, and `stall_o` is `in_valid` with at least one hazard. `cause_o` flags every active hazard: bit 3 RAW, bit 2 WAW, bit 1 divider busy, bit 0 write-back port taken.
- R8: The integer ALU, the FP adder and the multiplier accept a new independent instruction every cycle.
- R9: Unit class codes are: 0 integer, 1 load/store, 2 FP add, 3 multiply, 4 divide. Registers form one 64-entry space, with integer registers at 0–31 and FP registers at 32–63. An instruction with `in_dst_we` at 0 sets no register countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is waiting in decode |
| in_unit | input | 3 | Unit class code (R9) |
| in_dst | input | 6 | Destination register |
| in_dst_we | input | 1 | Instruction writes its destination |
| in_src1 | input | 6 | First source register |
| in_src1_en | input | 1 | First source is read |
| in_src2 | input | 6 | Second source register |
| in_src2_en | input | 1 | Second source is read |
| issue_o | output | 1 | Instruction leaves decode at this edge |
| stall_o | output | 1 | Instruction is held in decode; a bubble goes to execute |
| cause_o | output | 4 | Active hazard flags (R7) |

## Verification
The issue decision and its causes are combinational on the decode inputs. They are sampled in the same cycle the instruction is presented, 1 ns after the falling edge and before the next rising edge. Every effect of an issue on the tracking state, such as a countdown or a reservation, appears one edge later. Each expected stall count is therefore worked out as a cycle-by-cycle difference from the producer's issue cycle. The bench presents each table entry on the cycle after the previous one issues, counts the cycles in which `stall_o` is high before `issue_o` rises, and compares that count and the cause flags of the first stalled cycle with hand-derived values.

// File: rtl/iil_pkg.sv
package iil_pkg;

  typedef enum logic [2:0] {
    U_ALU  = 3'd0,
    U_MEM  = 3'd1,
    U_FADD = 3'd2,
    U_FMUL = 3'd3,
    U_DIV  = 3'd4
  } unit_e;

  typedef struct packed {
    logic raw;
    logic waw;
    logic unit_busy;
    logic port;
  } cause_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/iil_pending.sv
module iil_pending #(
  parameter int NREG = 64,
  parameter int CW   = 5,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_idx,
  input  logic [CW-1:0] wr_lat,
  input  logic [CW-1:0] wr_wb,
  input  logic [RW-1:0] rd_a,
  input  logic [RW-1:0] rd_b,
  input  logic [RW-1:0] rd_w,
  output logic [CW-1:0] cnt_a,
  output logic [CW-1:0] cnt_b,
  output logic [CW-1:0] wcnt_w
);

  logic [CW-1:0] rdy_q [NREG];
  logic [CW-1:0] wb_q  [NREG];

  always_ff @(posedge clk) begin
    for (int r = 0; r < NREG; r++) begin
      if (rst) begin
        rdy_q[r] <= '0;
        wb_q[r]  <= '0;
      end else if (wr_en && wr_idx == RW'(r)) begin
        rdy_q[r] <= wr_lat;
        wb_q[r]  <= wr_wb;
      end else begin
        if (rdy_q[r] != '0) rdy_q[r] <= rdy_q[r] - 1'b1;
        if (wb_q[r]  != '0) wb_q[r]  <= wb_q[r]  - 1'b1;
      end
    end
  end

  assign cnt_a  = rdy_q[rd_a];
  assign cnt_b  = rdy_q[rd_b];
  assign wcnt_w = wb_q[rd_w];

  // R9: a fresh write always loads the register's own countdown
  assert_load_seen_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_w == wr_idx) |=> (wcnt_w == $past(wr_wb)) || ($past(rd_w) != rd_w));

endmodule

// File: rtl/iil_wb_slots.sv
module iil_wb_slots #(
  parameter int SLOTS = 27,
  parameter int PW    = 5,
  localparam int SW   = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          claim,
  input  logic [PW-1:0] claim_pos,
  input  logic [PW-1:0] query_pos,
  output logic          taken
);

  logic [SLOTS-1:0] slot_q;
  logic [SLOTS-1:0] ahead;
  logic [SW-1:0]    ci;
  logic [SW-1:0]    qi;

  assign ahead = slot_q >> 1;
  assign ci    = SW'(claim_pos);
  assign qi    = SW'(query_pos);
  assign taken = slot_q[qi];

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
    end else begin
      slot_q <= ahead;
      if (claim) slot_q[ci] <= 1'b1;
    end
  end

  // R6: a claim never lands on a cycle already owned by another instruction
  assert_port_single_R6: assert property (@(posedge clk) disable iff (rst)
    claim |-> !ahead[ci]);

endmodule

// File: rtl/iil_div_gate.sv
module iil_div_gate #(
  parameter int II = 25,
  parameter int CW = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)                left_q <= '0;
    else if (start)         left_q <= CW'(II - 1);
    else if (left_q != '0)  left_q <= left_q - 1'b1;
  end

  assign busy = (left_q != '0);

  // R5: the divider is only started when idle
  assert_div_free_R5: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

  // R5: once started, the divider stays busy on the next cycle
  assert_div_hold_R5: assert property (@(posedge clk) disable iff (rst)
    start |=> busy || (II <= 1));

endmodule

// File: rtl/iil_issue_ctl.sv
module iil_issue_ctl
  import iil_pkg::*;
#(
  parameter int NREG     = 64,
  parameter int EX_ALU   = 1,
  parameter int EX_MEM   = 1,
  parameter int EX_FADD  = 4,
  parameter int EX_FMUL  = 7,
  parameter int EX_DIV   = 25,
  parameter int LAT_ALU  = 0,
  parameter int LAT_MEM  = 1,
  parameter int LAT_FADD = 3,
  parameter int LAT_FMUL = 6,
  parameter int LAT_DIV  = 24,
  parameter int DIV_II   = 25,
  localparam int RW      = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [2:0]    in_unit,
  input  logic [RW-1:0] in_dst,
  input  logic          in_dst_we,
  input  logic [RW-1:0] in_src1,
  input  logic          in_src1_en,
  input  logic [RW-1:0] in_src2,
  input  logic          in_src2_en,
  output logic          issue_o,
  output logic          stall_o,
  output logic [3:0]    cause_o
);

  localparam int MAXD  = imax(imax(imax(EX_ALU, EX_MEM), imax(EX_FADD, EX_FMUL)), EX_DIV);
  localparam int SLOTS = MAXD + 2;
  localparam int MAXL  = imax(imax(imax(LAT_ALU, LAT_MEM), imax(LAT_FADD, LAT_FMUL)), LAT_DIV);
  localparam int MAXV  = imax(imax(SLOTS, MAXL), DIV_II);
  localparam int CW    = $clog2(MAXV + 1);

  unit_e         unit;
  logic [CW-1:0] ex_d;
  logic [CW-1:0] lat_v;
  logic [CW-1:0] mem_at;
  logic [CW-1:0] rdy_a, rdy_b, wb_left;
  logic          port_taken;
  logic          div_busy;
  cause_t        cause;
  logic          hazard;

  assign unit = unit_e'(in_unit);

  always_comb begin
    case (unit)
      U_MEM:   begin ex_d = CW'(EX_MEM);  lat_v = CW'(LAT_MEM);  end
      U_FADD:  begin ex_d = CW'(EX_FADD); lat_v = CW'(LAT_FADD); end
      U_FMUL:  begin ex_d = CW'(EX_FMUL); lat_v = CW'(LAT_FMUL); end
      U_DIV:   begin ex_d = CW'(EX_DIV);  lat_v = CW'(LAT_DIV);  end
      default: begin ex_d = CW'(EX_ALU);  lat_v = CW'(LAT_ALU);  end
    endcase
  end

  assign mem_at = ex_d + 1'b1;

  iil_pending #(.NREG(NREG), .CW(CW)) u_pending (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (issue_o && in_dst_we),
    .wr_idx (in_dst),
    .wr_lat (lat_v),
    .wr_wb  (ex_d),
    .rd_a   (in_src1),
    .rd_b   (in_src2),
    .rd_w   (in_dst),
    .cnt_a  (rdy_a),
    .cnt_b  (rdy_b),
    .wcnt_w (wb_left)
  );

  iil_wb_slots #(.SLOTS(SLOTS), .PW(CW)) u_slots (
    .clk       (clk),
    .rst       (rst),
    .claim     (issue_o),
    .claim_pos (ex_d),
    .query_pos (mem_at),
    .taken     (port_taken)
  );

  iil_div_gate #(.II(DIV_II), .CW(CW)) u_div (
    .clk   (clk),
    .rst   (rst),
    .start (issue_o && unit == U_DIV),
    .busy  (div_busy)
  );

  always_comb begin
    cause.raw       = (in_src1_en && rdy_a != '0) || (in_src2_en && rdy_b != '0);
    cause.waw       = in_dst_we && (wb_left > ex_d);
    cause.unit_busy = (unit == U_DIV) && div_busy;
    cause.port      = port_taken;
  end

  assign hazard  = |cause;
  assign issue_o = in_valid && !hazard;
  assign stall_o = in_valid && hazard;
  assign cause_o = in_valid ? cause : 4'b0000;

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> (!issue_o && !stall_o && cause_o == 4'b0000));

  assert_issue_xor_stall_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (issue_o != stall_o));

  assert_raw_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (issue_o && in_src1_en) |-> (rdy_a == '0));

  assert_waw_order_R4: assert property (@(posedge clk) disable iff (rst)
    (issue_o && in_dst_we) |-> (wb_left <= ex_d));

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !stall_o);

endmodule

// File: tb/tb_iil_issue_ctl.sv
`timescale 1ns/1ps
module tb_iil_issue_ctl;

  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic [2:0] in_unit;
  logic [5:0] in_dst;
  logic       in_dst_we;
  logic [5:0] in_src1;
  logic       in_src1_en;
  logic [5:0] in_src2;
  logic       in_src2_en;
  logic       issue_o, stall_o;
  logic [3:0] cause_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  iil_issue_ctl dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_unit(in_unit),
    .in_dst(in_dst), .in_dst_we(in_dst_we), .in_src1(in_src1),
    .in_src1_en(in_src1_en), .in_src2(in_src2), .in_src2_en(in_src2_en),
    .issue_o(issue_o), .stall_o(stall_o), .cause_o(cause_o)
  );

  // entry: gap[38:33] unit[32:30] dst[29:24] we[23] s1[22:17] e1[16]
  //        s2[15:10] e2[9] stalls[8:4] first-stall cause[3:0]
  localparam int N = 24;
  localparam logic [38:0] TBL [N] = '{
    // RAW chain: load, mul, add, store (R3)
    {6'd30, 3'd1, 6'd36, 1'b1, 6'd2,  1'b1, 6'd0,  1'b0, 5'd0,  4'h0},
    {6'd0,  3'd3, 6'd32, 1'b1, 6'd36, 1'b1, 6'd38, 1'b1, 5'd1,  4'h8},
    {6'd0,  3'd2, 6'd34, 1'b1, 6'd32, 1'b1, 6'd40, 1'b1, 5'd6,  4'h8},
    {6'd0,  3'd1, 6'd0,  1'b0, 6'd34, 1'b1, 6'd2,  1'b1, 5'd3,  4'h8},
    // write-back port collisions (R6)
    {6'd30, 3'd3, 6'd42, 1'b1, 6'd52, 1'b1, 6'd53, 1'b1, 5'd0,  4'h0},
    {6'd0,  3'd0, 6'd1,  1'b1, 6'd3,  1'b1, 6'd4,  1'b1, 5'd0,  4'h0},
    {6'd0,  3'd0, 6'd5,  1'b1, 6'd3,  1'b1, 6'd4,  1'b1, 5'd0,  4'h0},
    {6'd0,  3'd2, 6'd43, 1'b1, 6'd54, 1'b1, 6'd55, 1'b1, 5'd1,  4'h1},
    {6'd0,  3'd1, 6'd44, 1'b1, 6'd6,  1'b1, 6'd0,  1'b0, 5'd0,  4'h0},
    {6'd0,  3'd0, 6'd7,  1'b1, 6'd3,  1'b1, 6'd4,  1'b1, 5'd2,  4'h1},
    // divider repeat interval (R5)
    {6'd30, 3'd4, 6'd33, 1'b1, 6'd50, 1'b1, 6'd51, 1'b1, 5'd0,  4'h0},
    {6'd0,  3'd4, 6'd37, 1'b1, 6'd56, 1'b1, 6'd57, 1'b1, 5'd24, 4'h2},
    // WAW ordering (R4), disabled source ignored (R3)
    {6'd30, 3'd3, 6'd39, 1'b1, 6'd58, 1'b1, 6'd59, 1'b1, 5'd0,  4'h0},
    {6'd0,  3'd2, 6'd39, 1'b1, 6'd60, 1'b1, 6'd61, 1'b1, 5'd3,  4'h4},
    {6'd0,  3'd1, 6'd39, 1'b1, 6'd29, 1'b1, 6'd0,  1'b0, 5'd3,  4'h4},
    {6'd0,  3'd0, 6'd8,  1'b1, 6'd39, 1'b0, 6'd9,  1'b0, 5'd0,  4'h0},
    // back-to-back pipelined units (R8), combined causes (R7)
    {6'd30, 3'd0, 6'd10, 1'b1, 6'd11, 1'b1, 6'd12, 1'b1, 5'd0,  4'h0},
    {6'd0,  3'd0, 6'd13, 1'b1, 6'd10, 1'b1, 6'd0,  1'b0, 5'd0,  4'h0},
    {6'd0,  3'd1, 6'd14, 1'b1, 6'd13, 1'b1, 6'd0,  1'b0, 5'd0,  4'h0},
    {6'd0,  3'd0, 6'd15, 1'b1, 6'd14, 1'b1, 6'd0,  1'b0, 5'd1,  4'h8},
    {6'd0,  3'd3, 6'd45, 1'b1, 6'd46, 1'b1, 6'd47, 1'b1, 5'd0,  4'h0},
    {6'd0,  3'd3, 6'd48, 1'b1, 6'd46, 1'b1, 6'd47, 1'b1, 5'd0,  4'h0},
    {6'd0,  3'd2, 6'd49, 1'b1, 6'd46, 1'b1, 6'd47, 1'b1, 5'd0,  4'h0},
    {6'd0,  3'd2, 6'd50, 1'b1, 6'd45, 1'b1, 6'd0,  1'b0, 5'd4,  4'h9}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] u, input logic [5:0] d, input logic we,
                       input logic [5:0] a, input logic ae, input logic [5:0] b, input logic be);
    in_valid = v; in_unit = u; in_dst = d; in_dst_we = we;
    in_src1 = a; in_src1_en = ae; in_src2 = b; in_src2_en = be;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    drive(1'b0, 3'd0, 6'd0, 1'b0, 6'd0, 1'b0, 6'd0, 1'b0);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1, R2: quiet after reset with nothing presented
    check(issue_o == 1'b0 && stall_o == 1'b0, "R1 reset outputs", {issue_o, stall_o}, 0);
    check(cause_o == 4'h0, "R2 idle cause", cause_o, 0);
    @(negedge clk);

    for (int k = 0; k < N; k++) begin
      logic [38:0] e;
      int stalls;
      int first;
      bit done;
      e = TBL[k];
      idle(int'(e[38:33]));
      drive(1'b1, e[32:30], e[29:24], e[23], e[22:17], e[16], e[15:10], e[9]);
      stalls = 0; first = 0; done = 1'b0;
      while (!done && stalls < 40) begin
        #1;
        if (issue_o) done = 1'b1;
        else begin
          if (stalls == 0) first = cause_o;
          stalls++;
        end
        @(negedge clk);
      end
      // R3 R4 R5 R6 R8: stall count per entry; R7: cause flags
      check(stalls == int'(e[8:4]), $sformatf("R3/R4/R5/R6/R8 entry %0d stalls", k), stalls, int'(e[8:4]));
      check(first == int'(e[3:0]), $sformatf("R7 entry %0d cause", k), first, int'(e[3:0]));
    end
    in_valid = 1'b0;

    // R5 boundary and R2 ignored inputs
    idle(30);
    drive(1'b1, 3'd4, 6'd20, 1'b1, 6'd21, 1'b1, 6'd22, 1'b1);
    #1; check(issue_o == 1'b1, "R1 divide issues when idle", issue_o, 1);
    @(negedge clk);
    for (int i = 1; i <= 23; i++) begin
      drive(1'b0, 3'd4, 6'd20, 1'b1, 6'd20, 1'b1, 6'd20, 1'b1);
      #1;
      if (i == 1 || i == 23)
        check(issue_o == 1'b0 && stall_o == 1'b0 && cause_o == 4'h0, "R2 invalid divide ignored",
              {issue_o, stall_o, cause_o}, 0);
      @(negedge clk);
    end
    drive(1'b1, 3'd4, 6'd23, 1'b1, 6'd24, 1'b1, 6'd25, 1'b1);
    #1; check(stall_o == 1'b1 && cause_o == 4'h2, "R5 divide at t+24 stalls", {stall_o, cause_o}, 6'h12);
    @(negedge clk);
    #1; check(issue_o == 1'b1, "R5 divide at t+25 issues", issue_o, 1);
    @(negedge clk);
    drive(1'b1, 3'd4, 6'd26, 1'b1, 6'd27, 1'b1, 6'd28, 1'b1);
    #1; check(stall_o == 1'b1, "R5 divide right after divide stalls", stall_o, 1);
    // R1: reset clears in-flight state
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1; check(issue_o == 1'b1 && cause_o == 4'h0, "R1 divide issues after reset", {issue_o, cause_o}, 16);
    @(negedge clk);
    // R9: a write-disabled instruction leaves no countdown behind
    drive(1'b1, 3'd3, 6'd30, 1'b0, 6'd0, 1'b0, 6'd0, 1'b0);
    @(negedge clk);
    drive(1'b1, 3'd0, 6'd31, 1'b1, 6'd30, 1'b1, 6'd0, 1'b0);
    #1; check(issue_o == 1'b1, "R9 no write, no RAW", issue_o, 1);
    @(negedge clk);
    in_valid = 1'b0;

    summary();
    $finish;
  end

endmodule